// File: doc/BRIEF.md
# Multi-function 8-bit ALU

This block combines arithmetic, bitwise logic, shifting and rotation in a single unit. It takes two 8-bit operands, a carry input and a 5-bit operation code. It produces a 16-bit result and four status flags: carry, borrow, overflow and zero. The operation is worked out combinationally, and the result and flags are captured in registers on the rising clock edge. Both therefore show up one cycle after the inputs are presented.

The 16-bit result bus lets multiplication return the full product. It also lets division return the quotient and the remainder together. Operations that make an 8-bit value leave the upper byte at zero. Codes 0x00 to 0x0F are defined. The upper half of the code space gives a zero result with every flag clear.

Top module: `octet_alu`

## Requirements
- R1: A synchronous active-high reset drives the result and all four flags to zero. Outside reset, the outputs reflect the inputs sampled at the previous rising edge.
- R2: Code 0x00 adds A+B and code 0x01 adds A+B+carry_in. The low byte is the sum, and the carry flag is the bit carried out of bit 7.
- R3: Code 0x02 computes A-B and code 0x03 computes A-B-carry_in. The low byte is the difference modulo 256. The borrow flag is set when B (plus carry_in for 0x03) is greater than A.
- R4: For codes 0x00 to 0x03, the overflow flag is set when the result, taken as an 8-bit two's-complement value, differs from the true signed sum or difference.
- R5: Code 0x04 returns the full unsigned 16-bit product A*B. The carry flag is set when the upper byte of the product is nonzero.
- R6: Code 0x05 with B nonzero returns the unsigned quotient A/B in the low byte and the remainder A%B in the high byte.
- R7: Code 0x05 with B equal to zero returns 0xFFFF and sets the overflow flag.
- R8: Code 0x06 returns A+1, with carry set when A=0xFF and overflow set when A=0x7F. Code 0x07 returns A-1, with borrow set when A=0x00 and overflow set when A=0x80.
- R9: Codes 0x08, 0x09, 0x0A and 0x0B return A AND B, A OR B, A XOR B and NOT A.
- R10: Code 0x0C shifts A left by one and fills bit 0 with zero. Code 0x0D shifts A right by one and fills bit 7 with zero. In both cases the carry flag receives the bit shifted out.
- R11: Code 0x0E rotates A left by one and code 0x0F rotates A right by one. The carry flag receives the bit that wraps around.
- R12: Every operation other than 0x04 and 0x05 leaves result bits 15:8 at zero. Any flag not named for an operation is zero.
- R13: For codes 0x00 to 0x0F, the zero flag is set exactly when all 16 result bits are zero.
- R14: Codes 0x10 to 0x1F give a zero result with the carry, borrow, overflow and zero flags all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| carry_in | input | 1 | Carry or borrow input for codes 0x01 and 0x03 |
| op_sel | input | 5 | Operation code |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry flag |
| borrow_out | output | 1 | Registered borrow flag |
| overflow_out | output | 1 | Registered overflow flag |
| zero_out | output | 1 | Registered zero flag |

## Verification
The bound checker watches, on every cycle, the properties that relate the previous cycle's inputs to the present outputs:
- the reset value;
- the response to unused codes;
- the divide-by-zero pattern;
- the upper byte staying clear for 8-bit operations;
- borrow appearing only for the subtracting codes;
- the zero flag agreeing with the 16-bit result.

The arithmetic values themselves can only be shown by the bench's scenarios. These are sums, differences, products, quotients and remainders, the signed overflow decisions, and the bit that leaves a shift or rotate. The bench compares them with a reference model over random operands and over directed edges such as 0x7F+1, 0xFF+1, 0x80-1, 0-0 and division by zero.

// File: rtl/octet_alu.sv
module octet_alu #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic           carry_in,
  input  logic [4:0]     op_sel,
  output logic [2*W-1:0] result,
  output logic           carry_out,
  output logic           borrow_out,
  output logic           overflow_out,
  output logic           zero_out
);
  localparam int RW = 2 * W;
  localparam logic [W-1:0] ZB = '0;

  logic [W:0]    add_w, sub_w, inc_w, dec_w;
  logic [RW-1:0] prod;
  logic [RW-1:0] nres;
  logic          nc, nb, nv, known;

  assign add_w = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, carry_in & op_sel[0]};
  assign sub_w = {1'b0, a_in} - {1'b0, b_in} - {{W{1'b0}}, carry_in & op_sel[0]};
  assign inc_w = {1'b0, a_in} + {{W{1'b0}}, 1'b1};
  assign dec_w = {1'b0, a_in} - {{W{1'b0}}, 1'b1};
  assign prod  = {ZB, a_in} * {ZB, b_in};

  always_comb begin
    nres  = '0;
    nc    = 1'b0;
    nb    = 1'b0;
    nv    = 1'b0;
    known = 1'b1;
    case (op_sel)
      5'h00, 5'h01: begin
        nres = {ZB, add_w[W-1:0]};
        nc   = add_w[W];
        nv   = (a_in[W-1] == b_in[W-1]) && (add_w[W-1] != a_in[W-1]);
      end
      5'h02, 5'h03: begin
        nres = {ZB, sub_w[W-1:0]};
        nb   = sub_w[W];
        nv   = (a_in[W-1] != b_in[W-1]) && (sub_w[W-1] != a_in[W-1]);
      end
      5'h04: begin
        nres = prod;
        nc   = |prod[RW-1:W];
      end
      5'h05: begin
        if (b_in == ZB) begin
          nres = '1;
          nv   = 1'b1;
        end else begin
          nres = {a_in % b_in, a_in / b_in};
        end
      end
      5'h06: begin
        nres = {ZB, inc_w[W-1:0]};
        nc   = inc_w[W];
        nv   = ~a_in[W-1] & inc_w[W-1];
      end
      5'h07: begin
        nres = {ZB, dec_w[W-1:0]};
        nb   = dec_w[W];
        nv   = a_in[W-1] & ~dec_w[W-1];
      end
      5'h08: nres = {ZB, a_in & b_in};
      5'h09: nres = {ZB, a_in | b_in};
      5'h0A: nres = {ZB, a_in ^ b_in};
      5'h0B: nres = {ZB, ~a_in};
      5'h0C: begin
        nres = {ZB, a_in[W-2:0], 1'b0};
        nc   = a_in[W-1];
      end
      5'h0D: begin
        nres = {ZB, 1'b0, a_in[W-1:1]};
        nc   = a_in[0];
      end
      5'h0E: begin
        nres = {ZB, a_in[W-2:0], a_in[W-1]};
        nc   = a_in[W-1];
      end
      5'h0F: begin
        nres = {ZB, a_in[0], a_in[W-1:1]};
        nc   = a_in[0];
      end
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      carry_out    <= 1'b0;
      borrow_out   <= 1'b0;
      overflow_out <= 1'b0;
      zero_out     <= 1'b0;
    end else begin
      result       <= nres;
      carry_out    <= nc;
      borrow_out   <= nb;
      overflow_out <= nv;
      zero_out     <= known && (nres == '0);
    end
  end
endmodule

// File: rtl/octet_alu_props.sv
module octet_alu_props #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic [4:0]     op_sel,
  input logic [2*W-1:0] result,
  input logic           carry_out,
  input logic           borrow_out,
  input logic           overflow_out,
  input logic           zero_out
);
  logic armed = 1'b0;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    live <= armed && !rst;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rst)) |->
      (result == '0 && !carry_out && !borrow_out && !overflow_out && !zero_out));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == 5'h05 && $past(b_in) == '0) |->
      (result == '1 && overflow_out));

  assert_upper_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) != 5'h04 && $past(op_sel) != 5'h05) |->
      (result[2*W-1:W] == '0));

  assert_borrow_source_R3: assert property (@(posedge clk) disable iff (rst)
    (live && borrow_out) |->
      ($past(op_sel) == 5'h02 || $past(op_sel) == 5'h03 || $past(op_sel) == 5'h07));

  assert_zero_flag_R13: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(op_sel[4])) |-> (zero_out == (result == '0)));

  assert_unused_code_R14: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel[4])) |->
      (result == '0 && !carry_out && !borrow_out && !overflow_out && !zero_out));
endmodule

bind octet_alu octet_alu_props #(.W(W)) u_props (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
  .result(result), .carry_out(carry_out), .borrow_out(borrow_out),
  .overflow_out(overflow_out), .zero_out(zero_out)
);

// File: tb/octet_alu_tb.sv
`timescale 1ns/1ps
module octet_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a_in = '0, b_in = '0;
  logic        carry_in = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [15:0] result;
  logic        carry_out, borrow_out, overflow_out, zero_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  octet_alu u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
    .op_sel(op_sel), .result(result), .carry_out(carry_out),
    .borrow_out(borrow_out), .overflow_out(overflow_out), .zero_out(zero_out)
  );

  function automatic string req_of(input logic [4:0] op, input logic [7:0] b);
    case (op)
      5'h00, 5'h01: return "R2";
      5'h02, 5'h03: return "R3";
      5'h04: return "R5";
      5'h05: return (b == 0) ? "R7" : "R6";
      5'h06, 5'h07: return "R8";
      5'h08, 5'h09, 5'h0A, 5'h0B: return "R9";
      5'h0C, 5'h0D: return "R10";
      5'h0E, 5'h0F: return "R11";
      default: return "R14";
    endcase
  endfunction

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // returns {result, carry, borrow, overflow, zero}
  function automatic logic [19:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [4:0] op);
    int ia, ib, ic, r, s;
    bit cy, bw, ov, z;
    ia = int'(a); ib = int'(b); ic = int'(c);
    r = 0; cy = 0; bw = 0; ov = 0;
    case (op)
      5'h00, 5'h01: begin
        if (op == 5'h00) ic = 0;
        r = ia + ib + ic; cy = (r > 255); r = r % 256;
        s = sgn(a) + sgn(b) + ic; ov = (s > 127) || (s < -128);
      end
      5'h02, 5'h03: begin
        if (op == 5'h02) ic = 0;
        bw = (ib + ic > ia); r = (ia - ib - ic + 512) % 256;
        s = sgn(a) - sgn(b) - ic; ov = (s > 127) || (s < -128);
      end
      5'h04: begin r = ia * ib; cy = (r > 255); end
      5'h05: begin
        if (ib == 0) begin r = 65535; ov = 1; end
        else r = (ia % ib) * 256 + ia / ib;
      end
      5'h06: begin r = (ia + 1) % 256; cy = (ia == 255); ov = (ia == 127); end
      5'h07: begin r = (ia + 255) % 256; bw = (ia == 0); ov = (ia == 128); end
      5'h08: r = int'(a & b);
      5'h09: r = int'(a | b);
      5'h0A: r = int'(a ^ b);
      5'h0B: r = 255 - ia;
      5'h0C: begin r = (ia * 2) % 256; cy = (ia >= 128); end
      5'h0D: begin r = ia / 2; cy = ia[0]; end
      5'h0E: begin r = (ia * 2) % 256 + ia / 128; cy = (ia >= 128); end
      5'h0F: begin r = ia / 2 + (ia % 2) * 128; cy = ia[0]; end
      default: r = 0;
    endcase
    z = (op < 16) && (r == 0);
    return {r[15:0], cy, bw, ov, z};
  endfunction

  task automatic compare(input string tag, input logic [19:0] exp);
    logic [19:0] got;
    got = {result, carry_out, borrow_out, overflow_out, zero_out};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual res=%h c=%b b=%b v=%b z=%b expected res=%h c=%b b=%b v=%b z=%b",
               tag, got[19:4], got[3], got[2], got[1], got[0],
               exp[19:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c,
                       input logic [4:0] op);
    @(negedge clk);
    a_in = a; b_in = b; carry_in = c; op_sel = op;
    @(posedge clk);
    @(negedge clk);
    compare(req_of(op, b), model(a, b, c, op));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset clears everything, even with live inputs
    a_in = 8'hFF; b_in = 8'hFF; op_sel = 5'h04; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", 20'h0);
    rst = 1'b0;

    // directed corners
    apply(8'h7F, 8'h01, 1'b0, 5'h00); // R4 positive overflow
    apply(8'hFF, 8'h01, 1'b0, 5'h00); // R2 carry, R13 zero result
    apply(8'hFF, 8'h00, 1'b1, 5'h01); // R2 carry from carry_in
    apply(8'h80, 8'h01, 1'b0, 5'h02); // R4 negative overflow
    apply(8'h00, 8'h00, 1'b0, 5'h02); // R13 zero
    apply(8'h05, 8'h05, 1'b1, 5'h03); // R3 borrow via carry_in
    apply(8'hFF, 8'hFF, 1'b0, 5'h04); // R5 max product
    apply(8'h00, 8'h37, 1'b0, 5'h04); // R13 zero product
    apply(8'hC8, 8'h07, 1'b0, 5'h05); // R6
    apply(8'h12, 8'h00, 1'b0, 5'h05); // R7
    apply(8'hFF, 8'h00, 1'b0, 5'h06); // R8 inc wrap
    apply(8'h7F, 8'h00, 1'b0, 5'h06); // R8 inc overflow
    apply(8'h00, 8'h00, 1'b0, 5'h07); // R8 dec borrow
    apply(8'h80, 8'h00, 1'b0, 5'h07); // R8 dec overflow
    apply(8'h81, 8'h00, 1'b0, 5'h0C); // R10
    apply(8'h81, 8'h00, 1'b0, 5'h0D); // R10
    apply(8'h81, 8'h00, 1'b0, 5'h0E); // R11
    apply(8'h81, 8'h00, 1'b0, 5'h0F); // R11
    apply(8'hFF, 8'hFF, 1'b0, 5'h0B); // R9 NOT to zero
    apply(8'hFF, 8'hFF, 1'b1, 5'h10); // R14
    apply(8'h00, 8'h00, 1'b0, 5'h1F); // R14 zero flag stays clear

    // R12 and all operations under random operands
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom), 5'($urandom));
    end

    // R1 again: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R1", 20'h0);
    rst = 1'b0;
    apply(8'h03, 8'h04, 1'b0, 5'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule